// File: doc/BRIEF.md
# Transmit Timestamp Capture Queue

This block keeps the egress times of frames sent with a two-step timestamp request. When such a frame leaves a port, the egress logic raises a one-cycle event strobe. With the strobe it presents the frame's timestamp tag, the egress port index and the message sequence number. In that same cycle the block samples the live time-of-day. It stores the low nanosecond bits of that time together with the parity of the current seconds count. Software later reads the seconds register of the clock and compares its lowest bit with the stored parity. When the two differ, a second boundary has passed since capture, and software subtracts one second to rebuild the full egress time.

The entries sit in a first-in first-out queue of parameterised depth. A small register port shows the oldest entry. One word gives a valid flag, a sticky overflow flag and the tag fields. A second word gives the stamp. A control word has two bits: one removes the oldest entry, and one clears the overflow flag. If an event arrives while the queue is full, the new entry is dropped and the overflow flag is raised. A removal and a capture in the same cycle both take effect.

Top module: `txts_capture_fifo`

## Requirements
- R1: After reset the queue is empty and both register words (status at address 0, stamp at address 1) read as zero.
- R2: An event stores the tag, port, sequence and the time-of-day present in the strobe cycle. The status word gives valid at bit 0, overflow at bit 1, port at bits [5:2], tag at bits [11:6] and sequence at bits [27:12]. The stamp word gives nanoseconds at bits [29:0] and the seconds parity at bit 30.
- R3: Entries come out in arrival order. Writing address 2 with bit 0 set removes the oldest entry, and the next one then becomes visible.
- R4: The valid bit is 1 exactly while the queue holds an entry. While the queue is empty, all field bits and the whole stamp word read zero.
- R5: A removal request on an empty queue has no effect.
- R6: An event that arrives while the queue is full and no removal happens in the same cycle is dropped. The stored entries stay unchanged and the overflow bit is set.
- R7: The overflow bit stays set across removals. Only a write of address 2 with bit 1 set clears it.
- R8: An event and a removal in the same cycle both take effect, also when the queue is full. In that case nothing is dropped and overflow is not set.
- R9: If a drop and an overflow clear fall in the same cycle, the overflow bit ends set.
- R10: An event and a removal in the same cycle on an empty queue store the event and ignore the removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | Egress event strobe, one cycle per frame |
| evt_tsid | input | 6 | Timestamp tag of the frame |
| evt_port | input | 4 | Egress port index |
| evt_seq | input | 16 | Message sequence number |
| tod_nsec | input | 30 | Live time-of-day, nanosecond part |
| tod_sec_lsb | input | 1 | Lowest bit of the live seconds count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 stamp, 2 control |
| reg_wdata | input | 2 | Control data: bit 0 remove oldest, bit 1 clear overflow |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A capture and a removal can fall in the same clock edge. The bench forces this on an empty queue, on a partly filled queue and on a full queue. It judges the result by the following status and stamp reads and by the order in which the entries drain. The overflow raise from a dropped capture is also driven in the same cycle as an overflow clear, and the bench checks that the flag ends set. A reference queue in the bench, updated with removal before insertion on each edge, supplies every expected word.

// File: rtl/txts_pkg.sv
package txts_pkg;
   typedef enum logic [1:0] {
      RA_STATUS = 2'd0,
      RA_STAMP  = 2'd1,
      RA_CTRL   = 2'd2,
      RA_SPARE  = 2'd3
   } txts_reg_e;

   localparam int REG_DW       = 32;
   localparam int CTL_W        = 2;
   localparam int CTL_NEXT_BIT = 0;
   localparam int CTL_CLR_BIT  = 1;
   localparam int ST_VALID_BIT = 0;
   localparam int ST_OVF_BIT   = 1;
   localparam int ST_FIELD_LSB = 2;
endpackage

// File: rtl/txts_ptr.sv
module txts_ptr #(
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] ptr
);
   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/txts_store.sv
module txts_store #(
   parameter int DEPTH = 4,
   parameter int DW    = 57,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [CW-1:0] occ,
   output logic          empty,
   output logic          drop
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, pop_ok, push_ok;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txts_store: DEPTH must be at least 2");
      end
   endgenerate

   assign empty   = (occ == '0);
   assign full    = (occ == CW'(DEPTH));
   assign pop_ok  = pop_req && !empty;
   assign push_ok = push_req && (!full || pop_ok);
   assign drop    = push_req && !push_ok;

   txts_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(push_ok), .ptr(wr_ptr));
   txts_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(pop_ok), .ptr(rd_ptr));

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else begin
         case ({push_ok, pop_ok})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign head = mem[rd_ptr];
endmodule

// File: rtl/txts_regif.sv
module txts_regif
   import txts_pkg::*;
#(
   parameter int ID_W   = 6,
   parameter int PORT_W = 4,
   parameter int SEQ_W  = 16,
   parameter int NS_W   = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [CTL_W-1:0]  reg_wdata,
   input  logic              empty,
   input  logic              drop,
   input  logic [ID_W-1:0]   h_id,
   input  logic [PORT_W-1:0] h_port,
   input  logic [SEQ_W-1:0]  h_seq,
   input  logic [NS_W-1:0]   h_ns,
   input  logic              h_sb,
   output logic              pop_req,
   output logic              ovf_flag,
   output logic [REG_DW-1:0] reg_rdata
);
   localparam int PORT_LSB = ST_FIELD_LSB;
   localparam int ID_LSB   = PORT_LSB + PORT_W;
   localparam int SEQ_LSB  = ID_LSB + ID_W;

   generate
      if (SEQ_LSB + SEQ_W > REG_DW) begin : g_bad_status
         $error("txts_regif: status fields exceed the register width");
      end
      if (NS_W + 1 > REG_DW) begin : g_bad_stamp
         $error("txts_regif: stamp exceeds the register width");
      end
   endgenerate

   txts_reg_e sel;
   logic      ctl_wr, clr_req;
   logic [REG_DW-1:0] status_w, stamp_w;

   assign sel     = txts_reg_e'(reg_addr);
   assign ctl_wr  = reg_wr && (sel == RA_CTRL);
   assign pop_req = ctl_wr && reg_wdata[CTL_NEXT_BIT];
   assign clr_req = ctl_wr && reg_wdata[CTL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (drop)    ovf_flag <= 1'b1;
      else if (clr_req) ovf_flag <= 1'b0;
   end

   always_comb begin
      status_w = '0;
      status_w[ST_VALID_BIT] = !empty;
      status_w[ST_OVF_BIT]   = ovf_flag;
      if (!empty) begin
         status_w[PORT_LSB +: PORT_W] = h_port;
         status_w[ID_LSB +: ID_W]     = h_id;
         status_w[SEQ_LSB +: SEQ_W]   = h_seq;
      end
   end

   always_comb begin
      stamp_w = '0;
      if (!empty) begin
         stamp_w[NS_W-1:0] = h_ns;
         stamp_w[NS_W]     = h_sb;
      end
   end

   always_comb begin
      case (sel)
         RA_STATUS: reg_rdata = status_w;
         RA_STAMP:  reg_rdata = stamp_w;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/txts_capture_fifo.sv
module txts_capture_fifo
   import txts_pkg::*;
#(
   parameter int ID_W   = 6,
   parameter int PORT_W = 4,
   parameter int SEQ_W  = 16,
   parameter int NS_W   = 30,
   parameter int DEPTH  = 4,
   localparam int EW    = ID_W + PORT_W + SEQ_W + NS_W + 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [ID_W-1:0]   evt_tsid,
   input  logic [PORT_W-1:0] evt_port,
   input  logic [SEQ_W-1:0]  evt_seq,
   input  logic [NS_W-1:0]   tod_nsec,
   input  logic              tod_sec_lsb,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [CTL_W-1:0]  reg_wdata,
   output logic [REG_DW-1:0] reg_rdata
);
   localparam int NS_LSB   = 1;
   localparam int SEQ_LSB  = NS_LSB + NS_W;
   localparam int PORT_LSB = SEQ_LSB + SEQ_W;
   localparam int ID_LSB   = PORT_LSB + PORT_W;

   logic [EW-1:0]    entry_in, head;
   logic [CNT_W-1:0] occ;
   logic             empty, drop, pop_req, ovf_flag;

   assign entry_in = {evt_tsid, evt_port, evt_seq, tod_nsec, tod_sec_lsb};

   txts_store #(.DEPTH(DEPTH), .DW(EW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push_req(evt_valid), .pop_req(pop_req), .wdata(entry_in),
      .head(head), .occ(occ), .empty(empty), .drop(drop));

   txts_regif #(.ID_W(ID_W), .PORT_W(PORT_W), .SEQ_W(SEQ_W), .NS_W(NS_W)) u_regif (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .empty(empty), .drop(drop),
      .h_id(head[ID_LSB +: ID_W]), .h_port(head[PORT_LSB +: PORT_W]),
      .h_seq(head[SEQ_LSB +: SEQ_W]), .h_ns(head[NS_LSB +: NS_W]),
      .h_sb(head[0]),
      .pop_req(pop_req), .ovf_flag(ovf_flag), .reg_rdata(reg_rdata));
endmodule

// File: rtl/txts_capture_fifo_chk.sv
module txts_capture_fifo_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_valid,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [1:0]       reg_wdata,
   input logic [CNT_W-1:0] occ,
   input logic             ovf
);
   logic nxt, clr, full, mt;
   assign nxt  = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];
   assign clr  = reg_wr && (reg_addr == 2'd2) && reg_wdata[1];
   assign full = (occ == CNT_W'(DEPTH));
   assign mt   = (occ == '0);

   AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> (mt && !ovf)); // R1
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !nxt && !full |=> occ == CNT_W'($past(occ) + 1'b1)); // R2
   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH)); // R3
   AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid && nxt && mt |=> mt); // R5
   AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && full && !nxt |=> ovf && full); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !clr |=> ovf); // R7
   AST_PUSH_POP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && nxt && !mt |=> $stable(occ)); // R8
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && full && !nxt && clr |=> ovf); // R9
   AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && nxt && mt |=> occ == CNT_W'(1)); // R10
endmodule

bind txts_capture_fifo txts_capture_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .occ(occ), .ovf(ovf_flag));

// File: tb/tb_txts_capture_fifo.sv
`timescale 1ns/100ps
module tb_txts_capture_fifo;
   localparam int DEPTH = 4;

   typedef struct packed {
      logic [5:0]  id;
      logic [3:0]  port;
      logic [15:0] seq;
      logic [29:0] ns;
      logic        sb;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        evt_valid;
   logic [5:0]  evt_tsid;
   logic [3:0]  evt_port;
   logic [15:0] evt_seq;
   logic [29:0] tod_nsec;
   logic        tod_sec_lsb;
   logic        reg_wr;
   logic [1:0]  reg_addr;
   logic [1:0]  reg_wdata;
   logic [31:0] reg_rdata;

   ent_t exp_q[$];
   bit   m_ovf;
   int   total = 0;
   int   bad = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   txts_capture_fifo #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_tsid(evt_tsid),
      .evt_port(evt_port), .evt_seq(evt_seq), .tod_nsec(tod_nsec),
      .tod_sec_lsb(tod_sec_lsb), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   function automatic ent_t mk(int k);
      ent_t e;
      e.id   = 6'(k * 7 + 1);
      e.port = 4'(k % 16);
      e.seq  = 16'(k * 4099 + 3);
      e.ns   = 30'(k * 123456789 + 17);
      e.sb   = k[0];
      return e;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h exp %h", tag, act, exp);
      end
   endtask

   // Driver: one clock of stimulus, reference queue updated after the edge
   task automatic step(bit ev, ent_t e, bit nxt, bit clr);
      bit drop;
      @(negedge clk);
      evt_valid   = ev;
      evt_tsid    = e.id;
      evt_port    = e.port;
      evt_seq     = e.seq;
      tod_nsec    = e.ns;
      tod_sec_lsb = e.sb;
      reg_wr      = nxt || clr;
      reg_addr    = 2'd2;
      reg_wdata   = {clr, nxt};
      @(posedge clk);
      drop = 1'b0;
      if (nxt && exp_q.size() > 0) void'(exp_q.pop_front());
      if (ev) begin
         if (exp_q.size() < DEPTH) exp_q.push_back(e);
         else drop = 1'b1;
      end
      if (drop) m_ovf = 1'b1;
      else if (clr) m_ovf = 1'b0;
      #1;
      evt_valid   = 1'b0;
      reg_wr      = 1'b0;
      reg_wdata   = 2'b00;
      tod_nsec    = ~e.ns;
      tod_sec_lsb = ~e.sb;
   endtask

   // Monitor: compare both read words with the reference head
   task automatic check_head(string tag);
      logic [31:0] st, sp, est, esp;
      @(negedge clk);
      reg_addr = 2'd0;
      #0.5 st = reg_rdata;
      reg_addr = 2'd1;
      #0.5 sp = reg_rdata;
      if (exp_q.size() > 0) begin
         est = {4'b0, exp_q[0].seq, exp_q[0].id, exp_q[0].port, m_ovf, 1'b1};
         esp = {1'b0, exp_q[0].sb, exp_q[0].ns};
      end else begin
         est = {30'b0, m_ovf, 1'b0};
         esp = '0;
      end
      chk({tag, " status"}, st, est);
      chk({tag, " stamp"}, sp, esp);
   endtask

   task automatic drain(string tag, int n);
      for (int i = 0; i < n; i++) begin
         check_head(tag);
         step(1'b0, '0, 1'b1, 1'b0);
      end
   endtask

   initial begin
      rst_n = 1'b0; evt_valid = 1'b0; evt_tsid = '0; evt_port = '0; evt_seq = '0;
      tod_nsec = '0; tod_sec_lsb = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
      m_ovf = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      check_head("R1 reset");

      // R2, R3: capture and ordered removal
      for (int k = 1; k <= 3; k++) step(1'b1, mk(k), 1'b0, 1'b0);
      check_head("R2 capture");
      drain("R3 order", 3);
      check_head("R4 empty");

      // R5: removal on empty queue
      step(1'b0, '0, 1'b1, 1'b0);
      check_head("R5 pop on empty");
      // R10: capture and removal on empty queue
      step(1'b1, mk(9), 1'b1, 1'b0);
      check_head("R10 both on empty");
      // R8: capture and removal with one entry queued
      step(1'b1, mk(10), 1'b1, 1'b0);
      check_head("R8 both partial");
      drain("R8 partial drain", 1);
      check_head("R4 empty again");

      // R6: overflow drops new entries
      for (int k = 20; k < 26; k++) step(1'b1, mk(k), 1'b0, 1'b0);
      check_head("R6 full");
      drain("R6 kept", 4);
      check_head("R7 sticky after drain");
      step(1'b0, '0, 1'b1, 1'b0);
      check_head("R7 next keeps flag");
      step(1'b0, '0, 1'b0, 1'b1);
      check_head("R7 cleared");

      // R8: capture and removal when full
      for (int k = 30; k < 34; k++) step(1'b1, mk(k), 1'b0, 1'b0);
      step(1'b1, mk(34), 1'b1, 1'b0);
      check_head("R8 both at full");
      drain("R8 order", 4);
      check_head("R8 empty");

      // R9: drop and clear in the same cycle
      for (int k = 40; k < 44; k++) step(1'b1, mk(k), 1'b0, 1'b0);
      step(1'b1, mk(44), 1'b0, 1'b1);
      check_head("R9 set wins");
      drain("R9 drain", 4);
      step(1'b0, '0, 1'b0, 1'b1);
      check_head("R9 cleared");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(50000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule